// File: doc/BRIEF.md
# Vectored Priority Interrupt Collector

The collector gathers 64 interrupt request lines and drives one interrupt line to a processor. Each source has its own configuration lane: a 2-bit priority level, an enable and a software-force bit. Every cycle the collector looks at the sources that are requesting, enabled and not blocked by the levels already in service. It picks the one at the highest level and registers that source's vector number. From the number it forms a vector address: the table base plus four bytes per source.

Software enters service for the presented interrupt in one of two ways. It can write the vector register, or, in read-side-effect mode, it can read that register. Service ends one priority level at a time through the level-acknowledge register. With nesting on, only a strictly higher level can interrupt a handler. With nesting off, nothing new is raised until every level has been acknowledged.

All registers sit on a single-cycle 32-bit register port. Each register answers at four addresses: a plain write, an OR-in alias, a bit-clear alias and a toggle alias.

Top module: `irq_collector`

## Requirements
- R1: Every register word answers at four addresses selected by address bits 3:2: 0 writes the value, 1 ORs it in, 2 clears the written bits, 3 toggles them. The scratch word at 0x1F0 shows all four.
- R2: Source n is configured in the word at 0x60 + 0x10*(n/4), in byte lane n mod 4. In that lane, bits 1:0 are the level, bit 2 is the enable and bit 3 is the software force. Lane bits 7:4 read back as zero.
- R3: The status word at 0x30 gives the presented vector number in bits 5:0. The vector word at 0x00 reads as the base (0x160, bits 31:2) plus four times that number.
- R4: The winner is the requesting, enabled, unblocked source with the highest level (3 is highest). On a tie the lowest source index wins.
- R5: When the global enable (control word at 0x20, bit 16) is clear, the interrupt output stays low.
- R6: With read-side-effect mode off, a write to the vector word while the interrupt output is high marks the presented source's level in service. The level-acknowledge word at 0x10 reads the in-service levels, one bit per level. With nesting on, only a source whose level is above every level in service can raise the output.
- R7: With nesting disabled (control bit 19), no interrupt is raised while any level is in service.
- R8: Writing a 1 to bit k of 0x10, through the plain or the OR-in alias, ends service at level k. A request still pending is then presented again.
- R9: With control bit 18 set, a read of the vector word enters service and a write to it does nothing.
- R10: The read-only words at 0x40 and 0x50 show the unmasked request lines 31:0 and 63:32.
- R11: A request is latched while its line is high. Writing a 1 through the plain or OR-in alias of the clear words (0x1D0 for sources 31:0, 0x1E0 for sources 63:32, bit n mod 32) discards the latched request. The force bit requests an interrupt with no line activity.
- R12: The scratch word at 0x1F0 is plain storage. Unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the address |
| irq_req | input | 64 | Interrupt request lines |
| cpu_irq | output | 1 | Interrupt to the processor |

## Verification
The bench raises each of the 64 lines on its own. This checks that every source maps to the right vector number and the right vector address, and that the clear words reach every bit. It then raises sources together at mixed levels and at equal levels, which separates a level-first choice from an index-first choice. Service sequences cover nesting on and off and both entry modes, and show whether blocking depends on the in-service levels or only on whether any level is busy. The register sequences apply each alias to known patterns and show that the four operations are distinct.

// File: rtl/icoll_pkg.sv
package icoll_pkg;
    parameter int NUM_SRC      = 64;
    parameter int LVL_W        = 2;
    parameter int LANE_W       = 8;
    parameter int SRC_PER_WORD = 4;
    localparam int NUM_LVL     = 1 << LVL_W;
    localparam int IDX_W       = $clog2(NUM_SRC);
    localparam int NUM_WORDS   = NUM_SRC / SRC_PER_WORD;
    localparam int WORD_IDX_W  = $clog2(NUM_WORDS);

    // register word index = byte address bits 11:4
    localparam logic [7:0] IDX_VEC   = 8'h00;
    localparam logic [7:0] IDX_ACK   = 8'h01;
    localparam logic [7:0] IDX_CTRL  = 8'h02;
    localparam logic [7:0] IDX_STAT  = 8'h03;
    localparam logic [7:0] IDX_RAW0  = 8'h04;
    localparam logic [7:0] IDX_RAW1  = 8'h05;
    localparam logic [7:0] IDX_INTR0 = 8'h06;
    localparam logic [7:0] IDX_VBASE = 8'h16;
    localparam logic [7:0] IDX_CLR0  = 8'h1D;
    localparam logic [7:0] IDX_CLR1  = 8'h1E;
    localparam logic [7:0] IDX_SCR   = 8'h1F;

    localparam int CTRL_GEN_BIT  = 16;
    localparam int CTRL_RSE_BIT  = 18;
    localparam int CTRL_NEST_BIT = 19;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } alias_e;

    typedef struct packed {
        logic             force_req;
        logic             en;
        logic [LVL_W-1:0] prio;
    } src_cfg_t;

    typedef struct packed {
        logic nest_dis;
        logic rse;
        logic gen;
    } ctrl_t;

    function automatic logic [31:0] alias_apply(input logic [31:0] cur,
                                                input logic [31:0] d,
                                                input alias_e op);
        case (op)
            OP_WRITE: return d;
            OP_SET:   return cur | d;
            OP_CLR:   return cur & ~d;
            default:  return cur ^ d;
        endcase
    endfunction

    function automatic logic [31:0] cfg_lane(input src_cfg_t c);
        return {{(32-LVL_W-2){1'b0}}, c};
    endfunction
endpackage

// File: rtl/icoll_regs.sv
module icoll_regs
    import icoll_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [11:0]                  bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [NUM_SRC-1:0]           irq_req,
    input  logic [IDX_W-1:0]             vec_num,
    input  logic [NUM_LVL-1:0]           inserv,
    output src_cfg_t [NUM_SRC-1:0]       cfg,
    output ctrl_t                        ctrl,
    output logic [NUM_SRC-1:0]           pend,
    output logic [NUM_LVL-1:0]           ack_bits,
    output logic                         take
);
    logic [7:0]  idx;
    alias_e      op;
    logic        pulse_op;
    logic [29:0] vbase;
    logic [31:0] scratch;
    logic [31:0] ctrl_word;
    logic [31:0] vec_word;
    logic [NUM_SRC-1:0] clr_vec;
    logic [31:0] intr_word [NUM_WORDS];
    logic [31:0] intr_next [NUM_WORDS];
    logic [NUM_WORDS-1:0] intr_hit;
    logic [7:0]  widx;

    assign idx      = bus_addr[11:4];
    assign op       = alias_e'(bus_addr[3:2]);
    assign pulse_op = (op == OP_WRITE) || (op == OP_SET);
    assign widx     = idx - IDX_INTR0;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_GEN_BIT]  = ctrl.gen;
        ctrl_word[CTRL_RSE_BIT]  = ctrl.rse;
        ctrl_word[CTRL_NEST_BIT] = ctrl.nest_dis;
    end

    assign vec_word = {vbase, 2'b00} + {{(30-IDX_W){1'b0}}, vec_num, 2'b00};

    genvar gw, gl;
    generate
        for (gw = 0; gw < NUM_WORDS; gw++) begin : g_word
            logic [31:0] packed_word;
            for (gl = 0; gl < SRC_PER_WORD; gl++) begin : g_lane
                assign packed_word[gl*LANE_W +: LANE_W] =
                    cfg_lane(cfg[gw*SRC_PER_WORD + gl])[LANE_W-1:0];
            end
            assign intr_word[gw] = packed_word;
            assign intr_next[gw] = alias_apply(packed_word, bus_wdata, op);
            assign intr_hit[gw]  = bus_wr && (idx == IDX_INTR0 + 8'(gw));
        end
    endgenerate

    // one-shot effects: level acknowledge, request discard, service entry
    always_comb begin
        ack_bits = '0;
        clr_vec  = '0;
        if (bus_wr && pulse_op && idx == IDX_ACK)
            ack_bits = bus_wdata[NUM_LVL-1:0];
        if (bus_wr && pulse_op && idx == IDX_CLR0)
            clr_vec[31:0] = bus_wdata;
        if (bus_wr && pulse_op && idx == IDX_CLR1)
            clr_vec[NUM_SRC-1:32] = bus_wdata[NUM_SRC-33:0];
    end

    assign take = (idx == IDX_VEC) && (ctrl.rse ? bus_rd : bus_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            ctrl    <= '0;
            vbase   <= '0;
            scratch <= '0;
            pend    <= '0;
        end else begin
            pend <= (pend & ~clr_vec) | irq_req;
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (intr_hit[w]) begin
                    for (int l = 0; l < SRC_PER_WORD; l++)
                        cfg[w*SRC_PER_WORD + l] <=
                            src_cfg_t'(intr_next[w][l*LANE_W +: (LVL_W+2)]);
                end
            end
            if (bus_wr && idx == IDX_CTRL) begin
                ctrl.gen      <= alias_apply(ctrl_word, bus_wdata, op)[CTRL_GEN_BIT];
                ctrl.rse      <= alias_apply(ctrl_word, bus_wdata, op)[CTRL_RSE_BIT];
                ctrl.nest_dis <= alias_apply(ctrl_word, bus_wdata, op)[CTRL_NEST_BIT];
            end
            if (bus_wr && idx == IDX_VBASE)
                vbase <= alias_apply({vbase, 2'b00}, bus_wdata, op)[31:2];
            if (bus_wr && idx == IDX_SCR)
                scratch <= alias_apply(scratch, bus_wdata, op);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (idx >= IDX_INTR0 && idx < IDX_VBASE) begin
            bus_rdata = intr_word[widx[WORD_IDX_W-1:0]];
        end else begin
            case (idx)
                IDX_VEC:   bus_rdata = vec_word;
                IDX_ACK:   bus_rdata = {{(32-NUM_LVL){1'b0}}, inserv};
                IDX_CTRL:  bus_rdata = ctrl_word;
                IDX_STAT:  bus_rdata = {{(32-IDX_W){1'b0}}, vec_num};
                IDX_RAW0:  bus_rdata = irq_req[31:0];
                IDX_RAW1:  bus_rdata = irq_req[NUM_SRC-1:32];
                IDX_VBASE: bus_rdata = {vbase, 2'b00};
                IDX_SCR:   bus_rdata = scratch;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/icoll_arbiter.sv
module icoll_arbiter
    import icoll_pkg::*;
(
    input  src_cfg_t [NUM_SRC-1:0] cfg,
    input  logic [NUM_SRC-1:0]     pend,
    input  logic [NUM_LVL-1:0]     inserv,
    input  logic                   nest_dis,
    output logic                   found,
    output logic [IDX_W-1:0]       win_idx,
    output logic [LVL_W-1:0]       win_lvl
);
    logic [NUM_LVL-1:0] lvl_ok;
    logic [NUM_SRC-1:0] cand;

    // a level may preempt only if no equal or higher level is in service
    always_comb begin
        for (int l = 0; l < NUM_LVL; l++)
            lvl_ok[l] = nest_dis ? (inserv == '0) : ((inserv >> l) == '0);
    end

    always_comb begin
        for (int n = 0; n < NUM_SRC; n++)
            cand[n] = (pend[n] | cfg[n].force_req) & cfg[n].en & lvl_ok[cfg[n].prio];
    end

    // strict compare keeps the lowest index among equal levels
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (cand[n] && (!found || cfg[n].prio > win_lvl)) begin
                found   = 1'b1;
                win_idx = IDX_W'(n);
                win_lvl = cfg[n].prio;
            end
        end
    end
endmodule

// File: rtl/icoll_service.sv
module icoll_service
    import icoll_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               gen,
    input  logic               found,
    input  logic [IDX_W-1:0]   win_idx,
    input  logic [LVL_W-1:0]   win_lvl,
    input  logic               take,
    input  logic [NUM_LVL-1:0] ack_bits,
    output logic               cpu_irq,
    output logic [IDX_W-1:0]   vec_num,
    output logic [LVL_W-1:0]   vec_lvl,
    output logic [NUM_LVL-1:0] inserv
);
    logic [NUM_LVL-1:0] enter;

    assign enter = (take && cpu_irq) ? (NUM_LVL'(1) << vec_lvl) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_irq <= 1'b0;
            vec_num <= '0;
            vec_lvl <= '0;
            inserv  <= '0;
        end else begin
            cpu_irq <= gen && found;
            if (found) begin
                vec_num <= win_idx;
                vec_lvl <= win_lvl;
            end
            inserv <= (inserv & ~ack_bits) | enter;
        end
    end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import icoll_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    output logic               cpu_irq
);
    src_cfg_t [NUM_SRC-1:0] cfg;
    ctrl_t                  ctrl;
    logic [NUM_SRC-1:0]     pend;
    logic [NUM_LVL-1:0]     ack_bits;
    logic [NUM_LVL-1:0]     inserv;
    logic                   take;
    logic                   found;
    logic [IDX_W-1:0]       win_idx;
    logic [LVL_W-1:0]       win_lvl;
    logic [IDX_W-1:0]       vec_num;
    logic [LVL_W-1:0]       vec_lvl;

    icoll_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_req  (irq_req),
        .vec_num  (vec_num),
        .inserv   (inserv),
        .cfg      (cfg),
        .ctrl     (ctrl),
        .pend     (pend),
        .ack_bits (ack_bits),
        .take     (take)
    );

    icoll_arbiter u_arb (
        .cfg     (cfg),
        .pend    (pend),
        .inserv  (inserv),
        .nest_dis(ctrl.nest_dis),
        .found   (found),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    icoll_service u_svc (
        .clk     (clk),
        .rst     (rst),
        .gen     (ctrl.gen),
        .found   (found),
        .win_idx (win_idx),
        .win_lvl (win_lvl),
        .take    (take),
        .ack_bits(ack_bits),
        .cpu_irq (cpu_irq),
        .vec_num (vec_num),
        .vec_lvl (vec_lvl),
        .inserv  (inserv)
    );
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk
    import icoll_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_rd,
    input logic [11:0]        bus_addr,
    input logic [31:0]        bus_rdata,
    input logic               cpu_irq,
    input logic               g_en,
    input logic               nest_dis,
    input logic [NUM_LVL-1:0] inserv,
    input logic               take,
    input logic [NUM_LVL-1:0] ack_bits,
    input logic [LVL_W-1:0]   vec_lvl
);
    logic [7:0] cidx;
    logic       unmapped;
    assign cidx     = bus_addr[11:4];
    assign unmapped = (cidx >= 8'h17 && cidx <= 8'h1C) || (cidx >= 8'h20);

    p_gen_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(g_en) |-> !cpu_irq);

    p_no_nest_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(nest_dis) && ($past(inserv) != '0)) |-> !cpu_irq);

    p_enter_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(take) && $past(cpu_irq) && ($past(ack_bits) == '0)) |-> inserv[$past(vec_lvl)]);

    p_ack_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (($past(ack_bits) != '0) && !($past(take) && $past(cpu_irq)))
            |-> ((inserv & $past(ack_bits)) == '0));

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && unmapped) |-> (bus_rdata == 32'h0));
endmodule

bind irq_collector irq_collector_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .cpu_irq  (cpu_irq),
    .g_en     (ctrl.gen),
    .nest_dis (ctrl.nest_dis),
    .inserv   (inserv),
    .take     (take),
    .ack_bits (ack_bits),
    .vec_lvl  (vec_lvl)
);

// File: tb/test_irq_collector.sv
`timescale 1ns/1ps
module test_irq_collector;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_req = '0;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [11:0] A_VEC   = 12'h000;
    localparam logic [11:0] A_ACK   = 12'h010;
    localparam logic [11:0] A_CTRL  = 12'h020;
    localparam logic [11:0] A_STAT  = 12'h030;
    localparam logic [11:0] A_RAW0  = 12'h040;
    localparam logic [11:0] A_RAW1  = 12'h050;
    localparam logic [11:0] A_INTR  = 12'h060;
    localparam logic [11:0] A_VBASE = 12'h160;
    localparam logic [11:0] A_CLR0  = 12'h1D0;
    localparam logic [11:0] A_SCR   = 12'h1F0;
    localparam logic [31:0] VB      = 32'h00A0_0000;

    always #5 clk = ~clk;

    irq_collector i_irq_collector (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic set_src(input int n, input int p, input bit en, input bit f);
        logic [11:0] a;
        int sh;
        a  = A_INTR + 12'(16 * (n / 4));
        sh = 8 * (n % 4);
        wr(a | 12'h8, 32'hFF << sh);
        wr(a | 12'h4, ({28'h0, f, en, 2'(p)}) << sh);
    endtask

    task automatic drop(input int n);
        @(negedge clk);
        irq_req[n] = 1'b0;
        wr((A_CLR0 + 12'(16 * (n / 32))) | 12'h4, 32'h1 << (n % 32));
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        chk("R6 reset irq", {31'h0, cpu_irq}, 32'h0);
        rchk("R3 reset stat", A_STAT, 32'h0);
        rchk("R3 reset vec", A_VEC, 32'h0);
        rchk("R6 reset inserv", A_ACK, 32'h0);

        // R1 alias operations on scratch
        wr(A_SCR, 32'h1234_5678);
        rchk("R1 plain", A_SCR, 32'h1234_5678);
        wr(A_SCR | 12'h4, 32'h0F00_0000);
        rchk("R1 set", A_SCR, 32'h1F34_5678);
        wr(A_SCR | 12'h8, 32'h0000_0078);
        rchk("R1 clear", A_SCR, 32'h1F34_5600);
        wr(A_SCR | 12'hC, 32'hFF00_00FF);
        rchk("R1 toggle", A_SCR, 32'hE034_56FF);

        // R12 unmapped ignored, scratch untouched
        wr(12'h170, 32'hFFFF_FFFF);
        rchk("R12 unmapped 0x170", 12'h170, 32'h0);
        rchk("R12 unmapped 0x300", 12'h300, 32'h0);
        rchk("R12 scratch kept", A_SCR, 32'hE034_56FF);

        // R2 lane layout
        wr(A_INTR, 32'hFFFF_FFFF);
        rchk("R2 lane width", A_INTR, 32'h0F0F_0F0F);
        wr(A_INTR | 12'hC, 32'h0000_0100);
        rchk("R2 toggle lane1", A_INTR, 32'h0F0F_0E0F);

        // setup: global enable, base, all sources enabled at level 0
        wr(A_CTRL, 32'h0001_0000);
        rchk("R5 ctrl readback", A_CTRL, 32'h0001_0000);
        wr(A_VBASE, VB | 32'h3);
        rchk("R3 vbase low bits", A_VBASE, VB);
        for (int w = 0; w < 16; w++) wr(A_INTR + 12'(16 * w), 32'h0404_0404);
        rchk("R2 word 5", A_INTR + 12'h50, 32'h0404_0404);

        // R3 / R11 sweep of every source
        for (int n = 0; n < 64; n++) begin
            @(negedge clk); irq_req[n] = 1'b1;
            idle(3);
            chk("R3 irq up", {31'h0, cpu_irq}, 32'h1);
            rchk("R3 stat", A_STAT, 32'(n));
            rchk("R3 vec addr", A_VEC, VB + 32'(4 * n));
            drop(n);
            idle(3);
            chk("R11 cleared", {31'h0, cpu_irq}, 32'h0);
        end

        // R10 raw view
        @(negedge clk); irq_req[3] = 1'b1; irq_req[35] = 1'b1;
        idle(1);
        rchk("R10 raw low", A_RAW0, 32'h8);
        rchk("R10 raw high", A_RAW1, 32'h8);
        drop(3); drop(35);

        // R4 priority and tie
        set_src(5, 1, 1, 0); set_src(40, 3, 1, 0); set_src(2, 3, 1, 0);
        @(negedge clk); irq_req[5] = 1; irq_req[40] = 1; irq_req[2] = 1;
        idle(3);
        rchk("R4 tie lowest index", A_STAT, 32'd2);
        drop(2); idle(3);
        rchk("R4 highest level", A_STAT, 32'd40);
        drop(40); idle(3);
        rchk("R4 next level", A_STAT, 32'd5);

        // R6 nesting on, R8 acknowledge
        wr(A_VEC, 32'h0);
        idle(3);
        rchk("R6 inserv lvl1", A_ACK, 32'h2);
        chk("R6 same level blocked", {31'h0, cpu_irq}, 32'h0);
        @(negedge clk); irq_req[40] = 1;
        idle(3);
        chk("R6 higher preempts", {31'h0, cpu_irq}, 32'h1);
        rchk("R6 preempt stat", A_STAT, 32'd40);
        wr(A_VEC, 32'h0);
        idle(3);
        rchk("R6 inserv nested", A_ACK, 32'hA);
        chk("R6 blocked again", {31'h0, cpu_irq}, 32'h0);
        wr(A_ACK | 12'h8, 32'h8);
        idle(3);
        rchk("R8 clear alias ignored", A_ACK, 32'hA);
        wr(A_ACK, 32'h8);
        idle(3);
        rchk("R8 ack lvl3", A_ACK, 32'h2);
        chk("R8 re-presented", {31'h0, cpu_irq}, 32'h1);
        drop(40);
        wr(A_ACK | 12'h4, 32'h2);
        idle(3);
        rchk("R8 all acked", A_ACK, 32'h0);
        rchk("R8 low source back", A_STAT, 32'd5);

        // R7 nesting disabled
        wr(A_CTRL | 12'h4, 32'h0008_0000);
        wr(A_VEC, 32'h0);
        @(negedge clk); irq_req[40] = 1;
        idle(3);
        chk("R7 no nest", {31'h0, cpu_irq}, 32'h0);
        wr(A_ACK, 32'h2);
        idle(3);
        chk("R7 after ack", {31'h0, cpu_irq}, 32'h1);
        rchk("R7 winner", A_STAT, 32'd40);
        drop(40);
        wr(A_CTRL | 12'h8, 32'h0008_0000);

        // R9 read side effect mode, source 5 still high
        wr(A_CTRL | 12'h4, 32'h0004_0000);
        idle(3);
        wr(A_VEC, 32'h0);
        idle(2);
        rchk("R9 write ignored", A_ACK, 32'h0);
        rchk("R9 read vec", A_VEC, VB + 32'd20);
        rchk("R9 read enters", A_ACK, 32'h2);
        wr(A_ACK, 32'hF);
        drop(5);
        wr(A_CTRL | 12'h8, 32'h0004_0000);

        // R5 global enable
        wr(A_CTRL | 12'h8, 32'h0001_0000);
        @(negedge clk); irq_req[5] = 1;
        idle(3);
        chk("R5 gated", {31'h0, cpu_irq}, 32'h0);
        wr(A_CTRL | 12'h4, 32'h0001_0000);
        idle(3);
        chk("R5 enabled", {31'h0, cpu_irq}, 32'h1);
        drop(5);

        // R11 latched pulse, discard, force
        @(negedge clk); irq_req[7] = 1;
        @(negedge clk); irq_req[7] = 0;
        idle(3);
        chk("R11 latched", {31'h0, cpu_irq}, 32'h1);
        rchk("R11 latched stat", A_STAT, 32'd7);
        wr(A_CLR0, 32'h80);
        idle(3);
        chk("R11 discarded", {31'h0, cpu_irq}, 32'h0);
        set_src(9, 0, 1, 1);
        idle(3);
        chk("R11 force", {31'h0, cpu_irq}, 32'h1);
        rchk("R11 force stat", A_STAT, 32'd9);
        set_src(9, 0, 1, 0);
        idle(3);
        chk("R11 force off", {31'h0, cpu_irq}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule